// File: doc/BRIEF.md
# Missing Transverse Energy Summer

This block takes, in every clock cycle, one scalar transverse-energy value for each of 18 azimuthal strips. Each strip is 20 degrees wide, and one LSB is about 1 GeV. The block forms three results from these values:

- the scalar sum of the energy;
- the signed x and y components of the visible energy vector, where each strip's value is weighted by the cosine and sine of its centre angle;
- the magnitude of the missing energy vector, with the quadrant it points into.

The projection coefficients are worked out at elaboration from the strip angles, so no table has to be loaded at run time. The block is fully pipelined and accepts a new event on every clock. A valid flag travels alongside the data, and the results come out a fixed number of cycles later. The block is meant to sit after the logic that forms strip sums in a calorimeter trigger. Downstream threshold logic reads its outputs directly.

Top module: `met_summer`

## Requirements
- R1: While `rst` is high, and on the first cycle after a clock edge that sampled it high, `out_vld` is 0 and every data output is 0.
- R2: Strip k (bits `in_et[10k+9:10k]`) has its centre at 10+20k degrees. Its x weight is round(256·cos) of that angle and its y weight is round(256·sin).
- R3: `out_tot` is the sum of the 18 strip values. When the sum exceeds 4095, the output saturates to 4095.
- R4: `out_ex` is floor(Σ et_k·wx_k / 256) and `out_ey` is floor(Σ et_k·wy_k / 256). Both are 16-bit two's complement, and no input combination overflows them.
- R5: `out_met` is floor(sqrt(Ex²+Ey²)). When that value exceeds 4095, the output saturates to 4095. The output is 0 exactly when Ex and Ey are both 0.
- R6: `out_quad` gives the quadrant of the missing vector (x,y) = (−Ex,−Ey), using these codes:
  - 0 for x>0 and y≥0;
  - 1 for x≤0 and y>0;
  - 2 for x<0 and y≤0;
  - 3 for x≥0 and y<0;
  - 0 for the null vector.
- R7: The block accepts one event per cycle. An event sampled at rising edge t appears on the outputs right after edge t+19, which is a latency of `ET_W+10` = 20 registers.
- R8: An event sampled with `in_vld` low produces `out_vld` low. Whenever `out_vld` is low, every data output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Event present on `in_et` |
| in_et | input | 180 | 18 unsigned strip energies, 10 bits each, strip 0 in the low bits |
| out_vld | output | 1 | Results belong to a valid event |
| out_tot | output | 12 | Saturated scalar energy sum |
| out_ex | output | 16 | Signed x component of the visible energy |
| out_ey | output | 16 | Signed y component of the visible energy |
| out_met | output | 12 | Saturated missing energy magnitude |
| out_quad | output | 2 | Quadrant of the missing energy vector |

## Verification
A wrong projection weight for one strip shows up in `out_ex` or `out_ey` 20 cycles after the first event that lights that strip. A bad step in the square-root chain shows up in the same cycle as a magnitude whose square no longer brackets Ex²+Ey². The bench lights each strip in turn and then applies sums, boundary angles and saturating loads, so a fault in a single strip or in a single stage reaches the ports within one latency. A dropped or stuck valid bit appears at once, either as gated zeros or as data flagged on an idle cycle.

// File: rtl/met_summer.sv
module met_summer #(
  parameter int N_STRIP = 18,
  parameter int ET_W    = 10,
  parameter int OUT_W   = 12,
  localparam int EXY_W   = ET_W + 6,
  localparam int LATENCY = EXY_W + 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_vld,
  input  logic [N_STRIP*ET_W-1:0]     in_et,
  output logic                        out_vld,
  output logic [OUT_W-1:0]            out_tot,
  output logic signed [EXY_W-1:0]     out_ex,
  output logic signed [EXY_W-1:0]     out_ey,
  output logic [OUT_W-1:0]            out_met,
  output logic [1:0]                  out_quad
);
  localparam int FRAC  = 8;
  localparam int CW    = FRAC + 2;
  localparam int PW    = ET_W + CW + 1;
  localparam int SUM_W = PW + $clog2(N_STRIP) + 1;
  localparam int TOT_W = ET_W + $clog2(N_STRIP) + 1;
  localparam int SQ_W  = 2 * EXY_W;
  localparam int REM_W = EXY_W + 2;
  localparam int STEP  = 360 / N_STRIP;
  localparam int HALF  = STEP / 2;

  function automatic int q8(input int d);
    case (d / 10)
      0: return 256;
      1: return 252;
      2: return 241;
      3: return 222;
      4: return 196;
      5: return 165;
      6: return 128;
      7: return 88;
      8: return 44;
      default: return 0;
    endcase
  endfunction

  function automatic int wcos(input int deg);
    int d;
    d = deg % 360;
    if (d <= 90)       return q8(d);
    else if (d <= 180) return -q8(180 - d);
    else if (d <= 270) return -q8(d - 180);
    else               return q8(360 - d);
  endfunction

  // stage 1: per-strip projections and scalar sum
  logic signed [PW-1:0]    px [N_STRIP];
  logic signed [PW-1:0]    py [N_STRIP];
  logic [TOT_W-1:0]        tot_c, tot1, tot2;
  logic                    v1, v2;

  always_comb begin
    tot_c = '0;
    for (int k = 0; k < N_STRIP; k++)
      tot_c = tot_c + TOT_W'(in_et[k*ET_W +: ET_W]);
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < N_STRIP; k++) begin
      px[k] <= $signed({1'b0, in_et[k*ET_W +: ET_W]}) * $signed(CW'(wcos(HALF + STEP*k)));
      py[k] <= $signed({1'b0, in_et[k*ET_W +: ET_W]}) * $signed(CW'(wcos(HALF + STEP*k + 270)));
    end
    tot1 <= tot_c;
  end

  // stage 2: component sums
  logic signed [SUM_W-1:0] sx_c, sy_c;
  logic signed [EXY_W-1:0] ex2, ey2;

  always_comb begin
    sx_c = '0;
    sy_c = '0;
    for (int k = 0; k < N_STRIP; k++) begin
      sx_c = sx_c + SUM_W'(px[k]);
      sy_c = sy_c + SUM_W'(py[k]);
    end
  end

  always_ff @(posedge clk) begin
    ex2  <= sx_c[FRAC +: EXY_W];
    ey2  <= sy_c[FRAC +: EXY_W];
    tot2 <= tot1;
  end

  // stage 3 onward: squared norm, then one root bit per stage
  logic [SQ_W-1:0]         rad   [EXY_W];
  logic [EXY_W-1:0]        rem   [EXY_W];
  logic [EXY_W-1:0]        root  [EXY_W+1];
  logic [REM_W-1:0]        cand  [EXY_W];
  logic [REM_W-1:0]        trial [EXY_W];
  logic                    ge    [EXY_W];
  logic                    dv    [EXY_W+1];
  logic [TOT_W-1:0]        dtot  [EXY_W+1];
  logic signed [EXY_W-1:0] dex   [EXY_W+1];
  logic signed [EXY_W-1:0] dey   [EXY_W+1];

  always_comb begin
    for (int i = 0; i < EXY_W; i++) begin
      cand[i]  = {rem[i], rad[i][SQ_W-1 -: 2]};
      trial[i] = {root[i], 2'b01};
      ge[i]    = cand[i] >= trial[i];
    end
  end

  always_ff @(posedge clk) begin
    rad[0]  <= SQ_W'(ex2 * ex2 + ey2 * ey2);
    rem[0]  <= '0;
    root[0] <= '0;
    dtot[0] <= tot2;
    dex[0]  <= ex2;
    dey[0]  <= ey2;
    for (int i = 0; i < EXY_W; i++) begin
      root[i+1] <= {root[i][EXY_W-2:0], ge[i]};
      dtot[i+1] <= dtot[i];
      dex[i+1]  <= dex[i];
      dey[i+1]  <= dey[i];
    end
    for (int i = 0; i < EXY_W - 1; i++) begin
      rad[i+1] <= rad[i] << 2;
      rem[i+1] <= EXY_W'(ge[i] ? cand[i] - trial[i] : cand[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      for (int i = 0; i <= EXY_W; i++) dv[i] <= 1'b0;
    end else begin
      v1    <= in_vld;
      v2    <= v1;
      dv[0] <= v2;
      for (int i = 0; i < EXY_W; i++) dv[i+1] <= dv[i];
    end
  end

  // output stage: saturation, quadrant, valid gating
  logic signed [EXY_W-1:0] fx, fy;
  logic [1:0]              quad_c;
  assign fx = dex[EXY_W];
  assign fy = dey[EXY_W];

  always_comb begin
    quad_c = 2'd0;
    if (fx >= 0 && fy < 0)       quad_c = 2'd1;
    else if (fx > 0 && fy >= 0)  quad_c = 2'd2;
    else if (fx <= 0 && fy > 0)  quad_c = 2'd3;
  end

  always_ff @(posedge clk) begin
    if (rst || !dv[EXY_W]) begin
      out_vld  <= 1'b0;
      out_tot  <= '0;
      out_ex   <= '0;
      out_ey   <= '0;
      out_met  <= '0;
      out_quad <= '0;
    end else begin
      out_vld  <= 1'b1;
      out_tot  <= |dtot[EXY_W][TOT_W-1:OUT_W] ? '1 : dtot[EXY_W][OUT_W-1:0];
      out_met  <= |root[EXY_W][EXY_W-1:OUT_W] ? '1 : root[EXY_W][OUT_W-1:0];
      out_ex   <= fx;
      out_ey   <= fy;
      out_quad <= quad_c;
    end
  end
endmodule

// File: rtl/met_summer_chk.sv
module met_summer_chk #(
  parameter int ET_W  = 10,
  parameter int OUT_W = 12,
  parameter int LAT   = 20
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_vld,
  input logic                   out_vld,
  input logic [OUT_W-1:0]       out_tot,
  input logic signed [ET_W+5:0] out_ex,
  input logic signed [ET_W+5:0] out_ey,
  input logic [OUT_W-1:0]       out_met,
  input logic [1:0]             out_quad
);
  localparam int IW = $clog2(LAT + 1);

  logic [IW-1:0] idle;
  longint        sq, m;

  always_ff @(posedge clk) begin
    if (rst || in_vld)           idle <= '0;
    else if (idle < IW'(LAT))    idle <= idle + 1'b1;
  end

  always_comb begin
    sq = longint'(out_ex) * longint'(out_ex) + longint'(out_ey) * longint'(out_ey);
    m  = longint'(out_met);
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_vld && out_tot == '0 && out_met == '0));

  a_r8_invalid_zero: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> (out_tot == '0 && out_met == '0 && out_ex == '0 && out_ey == '0 && out_quad == 2'd0));

  a_r8_idle_drains: assert property (@(posedge clk) disable iff (rst)
    (idle >= IW'(LAT)) |-> !out_vld);

  a_r5_root_bracket: assert property (@(posedge clk) disable iff (rst)
    (out_vld && out_met != '1) |-> (m * m <= sq && (m + 1) * (m + 1) > sq));

  a_r5_zero_iff_null: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> ((out_met == '0) == (out_ex == '0 && out_ey == '0)));
endmodule

bind met_summer met_summer_chk #(.ET_W(ET_W), .OUT_W(OUT_W), .LAT(LATENCY)) u_chk (
  .clk(clk), .rst(rst), .in_vld(in_vld), .out_vld(out_vld), .out_tot(out_tot),
  .out_ex(out_ex), .out_ey(out_ey), .out_met(out_met), .out_quad(out_quad)
);

// File: tb/test_met_summer.sv
module test_met_summer;
  localparam int NS  = 18;
  localparam int LAT = 20;
  localparam real PI = 3.14159265358979;

  logic               clk = 1'b0;
  logic               rst;
  logic               in_vld;
  logic [NS*10-1:0]   in_et;
  logic               out_vld;
  logic [11:0]        out_tot, out_met;
  logic signed [15:0] out_ex, out_ey;
  logic [1:0]         out_quad;

  met_summer i_met_summer (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_et(in_et), .out_vld(out_vld),
    .out_tot(out_tot), .out_ex(out_ex), .out_ey(out_ey), .out_met(out_met), .out_quad(out_quad)
  );

  always #5 clk = ~clk;

  typedef struct { bit v; int tot; int ex; int ey; int met; int quad; } exp_t;
  exp_t q[$];
  int checks = 0, failures = 0;
  bit done = 0;
  int et [NS];
  int seed = 7;

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
    end
  endtask

  function automatic exp_t model(input bit v, input int e [NS]);
    exp_t r;
    int sx = 0, sy = 0, tot = 0;
    longint s, rt;
    r = '{0, 0, 0, 0, 0, 0};
    if (!v) return r;
    for (int k = 0; k < NS; k++) begin
      real a = (10.0 + 20.0 * k) * PI / 180.0;
      sx += e[k] * int'(256.0 * $cos(a));
      sy += e[k] * int'(256.0 * $sin(a));
      tot += e[k];
    end
    r.v   = 1;
    r.ex  = sx >>> 8;
    r.ey  = sy >>> 8;
    r.tot = tot > 4095 ? 4095 : tot;
    s  = longint'(r.ex) * r.ex + longint'(r.ey) * r.ey;
    rt = longint'($floor($sqrt(real'(s))));
    while (rt * rt > s) rt--;
    while ((rt + 1) * (rt + 1) <= s) rt++;
    r.met = rt > 4095 ? 4095 : int'(rt);
    if (-r.ex > 0 && -r.ey >= 0)       r.quad = 0;
    else if (-r.ex <= 0 && -r.ey > 0)  r.quad = 1;
    else if (-r.ex < 0 && -r.ey <= 0)  r.quad = 2;
    else if (-r.ex >= 0 && -r.ey < 0)  r.quad = 3;
    else                               r.quad = 0;
    return r;
  endfunction

  task automatic step(input bit v);
    exp_t e;
    if (q.size() == LAT) begin
      e = q.pop_front();
      chk("R7/R8 out_vld", int'(out_vld), int'(e.v));
      chk("R3 out_tot", int'(out_tot), e.tot);
      chk("R2/R4 out_ex", int'(out_ex), e.ex);
      chk("R2/R4 out_ey", int'(out_ey), e.ey);
      chk("R5 out_met", int'(out_met), e.met);
      chk("R6 out_quad", int'(out_quad), e.quad);
    end
    in_vld = v;
    for (int k = 0; k < NS; k++) in_et[k*10 +: 10] = 10'(et[k]);
    q.push_back(model(v, et));
    @(negedge clk);
  endtask

  function automatic int lcg();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 8) & 32'h7fffffff;
  endfunction

  task automatic fill(input int val);
    for (int k = 0; k < NS; k++) et[k] = val;
  endtask

  initial begin
    exp_t z;
    rst = 1'b1; in_vld = 1'b0; in_et = '0;
    fill(0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset out_vld", int'(out_vld), 0);
    chk("R1 reset out_met", int'(out_met), 0);
    chk("R1 reset out_tot", int'(out_tot), 0);
    rst = 1'b0;
    z = model(0, et);
    for (int i = 0; i < LAT; i++) q.push_back(z);

    step(1);                                      // null event, R5 zero
    for (int k = 0; k < NS; k++) begin             // R2 each strip alone, R6 quadrants
      fill(0); et[k] = 1023; step(1);
    end
    fill(0); et[9] = 1; step(1);                  // R4 floor of a negative fraction
    fill(0); et[0] = 100; step(1);
    fill(1023); step(1);                          // R3 saturation, balanced vector
    fill(0); for (int k = 0; k < 9; k++) et[k] = 1023; step(1);   // R5 saturation
    fill(0); et[4] = 500; step(1);                // R6 x = 0 boundary
    fill(0); et[13] = 500; step(1);
    fill(7); step(0);                             // R8 invalid event
    fill(3); step(1);
    for (int n = 0; n < 120; n++) begin           // R7 back-to-back mixed traffic
      for (int k = 0; k < NS; k++) et[k] = (n % 3 == 0) ? lcg() % 1024 : lcg() % 64;
      step((lcg() % 5) != 0);
    end
    fill(0);
    for (int n = 0; n < LAT + 2; n++) step(0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual running expected done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule